// File: doc/BRIEF.md
# Local/Remote Interrupt Router

This block decides where the interrupts of a serial bridge end up. Interrupt requests are raised in two ways. Software writes ones into a pending/set register, and the local and far-side serial bus error inputs pulse. A routing bit in the control register picks one of two destinations. With the bit set, each request lands in a status/clear register, and the OR of that register drives one host interrupt line. With the bit clear, requests build up in the pending register and are offered to the packet transmitter as an outbound interrupt request that carries a status vector.

Status that arrives in an interrupt packet from the far side comes in as a vector with a one-cycle valid strobe. A second control bit decides where it goes. It is either merged into the local status register, or issued as a one-cycle write of that vector to the address held in the pointer register. Packet framing is handled elsewhere.

The outbound request uses valid/ready. Once `pkt_valid` is high, `pkt_vec` does not change until the cycle in which `pkt_ready` is also high. The receiver may hold `pkt_ready` low for as long as it needs. The inbound vector and the pointer write are strobes and have no back-pressure: the router always accepts `rx_valid`, and the consumer of `ptr_wr_valid` must take the write in that cycle.

Top module: `irq_router`

## Requirements
- R1: After reset the control, pending, status and pointer registers read zero, and `host_irq` and `pkt_valid` are low.
- R2: With control bit 0 (local routing) at 1, a write of ones to the pending register (address 1) or an error pulse sets the matching status bits one cycle later, and the pending register is left unchanged.
- R3: A pulse on `err_local` raises interrupt bit 13 and a pulse on `err_remote` raises bit 14. The status vector is 15 bits wide, bits 0 to 14.
- R4: Writing the status register (address 2) clears each bit written as 1 and leaves bits written as 0 unchanged. A bit that is set and cleared in the same cycle ends up set.
- R5: `host_irq` is high exactly when any status bit is 1.
- R6: With control bit 0 at 0, requests accumulate in the pending register. When `pkt_valid` is low and the pending register is non-zero, `pkt_valid` rises one cycle later, and `pkt_vec` equals the pending register as it stood in that cycle.
- R7: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` and `pkt_vec` stay constant.
- R8: In a cycle with `pkt_valid` and `pkt_ready` both high, the pending bits present in `pkt_vec` are cleared, requests arriving in that cycle are kept, and `pkt_valid` is low in the next cycle.
- R9: With control bit 1 (redirect) at 0, an `rx_valid` cycle ORs `rx_vec` into the status register one cycle later.
- R10: With control bit 1 at 1, an `rx_valid` cycle produces, one cycle later, a single-cycle `ptr_wr_valid` with `ptr_wr_addr` equal to the pointer register and `ptr_wr_data` equal to `rx_vec`. Status is left unchanged.
- R11: Register addresses are 0 for control (bits 1:0), 1 for pending, 2 for status and 3 for the pointer. `reg_rdata` shows the addressed register in the same cycle, with unused upper bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| err_local | input | 1 | Local serial bus error pulse |
| err_remote | input | 1 | Far-side serial bus error pulse |
| pkt_valid | output | 1 | Outbound interrupt packet request |
| pkt_ready | input | 1 | Transmitter accepts the request |
| pkt_vec | output | 15 | Status vector for the outbound packet |
| rx_valid | input | 1 | Inbound interrupt status strobe |
| rx_vec | input | 15 | Inbound interrupt status |
| ptr_wr_valid | output | 1 | Redirected status write strobe |
| ptr_wr_addr | output | 32 | Target address of the redirected write |
| ptr_wr_data | output | 15 | Redirected status |
| host_irq | output | 1 | Host interrupt line |

## Verification
A wrong status bit shows on `host_irq` and on a status read in the cycle after the update that caused it. A pending register that was cleared too much or too little shows on the next `pkt_vec` snapshot, one cycle after an acknowledge at the earliest. A wrong routing decision, for either requests or inbound status, makes the wrong port move within one cycle, and the port that should have moved stays still. The reference model checks every output and the currently addressed register on every clock, so a divergence is caught in the cycle it first becomes visible.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_PEND = 2'd1,
    RA_STAT = 2'd2,
    RA_PTR  = 2'd3
  } reg_addr_e;

  localparam int CTRL_LOCAL_BIT    = 0;
  localparam int CTRL_REDIRECT_BIT = 1;
  localparam int CTRL_W            = 2;
endpackage

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl #(
  parameter int NVEC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] set_vec,
  input  logic            local_mode,
  input  logic            pkt_ready,
  output logic            pkt_valid,
  output logic [NVEC-1:0] pkt_vec,
  output logic [NVEC-1:0] pend
);
  logic            ack;
  logic [NVEC-1:0] sent_mask;
  logic [NVEC-1:0] add_mask;

  assign ack       = pkt_valid & pkt_ready;
  assign sent_mask = ack ? pkt_vec : '0;
  assign add_mask  = local_mode ? '0 : set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~sent_mask) | add_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_vec   <= '0;
    end else if (ack) begin
      pkt_valid <= 1'b0;
    end else if (!pkt_valid && !local_mode && (pend != '0)) begin
      pkt_valid <= 1'b1;
      pkt_vec   <= pend;
    end
  end

  // R7
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_vec)));

  // R8
  pkt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> !pkt_valid);
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int NVEC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] set_vec,
  input  logic [NVEC-1:0] clr_vec,
  output logic [NVEC-1:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else begin
      stat <= (stat & ~clr_vec) | set_vec;
    end
  end

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((stat & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/irq_remote_in.sv
module irq_remote_in #(
  parameter int NVEC = 15,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [NVEC-1:0] rx_vec,
  input  logic            redirect,
  input  logic [AW-1:0]   ptr,
  output logic [NVEC-1:0] to_stat,
  output logic            wr_valid,
  output logic [AW-1:0]   wr_addr,
  output logic [NVEC-1:0] wr_data
);
  assign to_stat = (rx_valid && !redirect) ? rx_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= rx_valid && redirect;
      if (rx_valid && redirect) begin
        wr_addr <= ptr;
        wr_data <= rx_vec;
      end
    end
  end

  // R10
  redirect_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && redirect) |=> (wr_valid && wr_data == $past(rx_vec)));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NVEC     = 15,
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int LERR_BIT = 13,
  parameter int RERR_BIT = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            err_local,
  input  logic            err_remote,
  output logic            pkt_valid,
  input  logic            pkt_ready,
  output logic [NVEC-1:0] pkt_vec,
  input  logic            rx_valid,
  input  logic [NVEC-1:0] rx_vec,
  output logic            ptr_wr_valid,
  output logic [AW-1:0]   ptr_wr_addr,
  output logic [NVEC-1:0] ptr_wr_data,
  output logic            host_irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [AW-1:0]     ptr;
  logic [NVEC-1:0]   pend;
  logic [NVEC-1:0]   stat;
  logic [NVEC-1:0]   req_vec;
  logic [NVEC-1:0]   err_vec;
  logic [NVEC-1:0]   local_set;
  logic [NVEC-1:0]   rx_set;
  logic [NVEC-1:0]   clr_vec;
  logic              local_mode;
  logic              redirect;
  reg_addr_e         addr;

  assign addr       = reg_addr_e'(reg_addr);
  assign local_mode = ctrl[CTRL_LOCAL_BIT];
  assign redirect   = ctrl[CTRL_REDIRECT_BIT];

  always_comb begin
    err_vec           = '0;
    err_vec[LERR_BIT] = err_local;
    err_vec[RERR_BIT] = err_remote;
  end

  assign req_vec   = ((reg_we && addr == RA_PEND) ? reg_wdata[NVEC-1:0] : '0) | err_vec;
  assign local_set = local_mode ? req_vec : '0;
  assign clr_vec   = (reg_we && addr == RA_STAT) ? reg_wdata[NVEC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      ptr  <= '0;
    end else if (reg_we) begin
      if (addr == RA_CTRL) ctrl <= reg_wdata[CTRL_W-1:0];
      if (addr == RA_PTR)  ptr  <= reg_wdata[AW-1:0];
    end
  end

  irq_pend_ctl #(.NVEC(NVEC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (req_vec),
    .local_mode(local_mode),
    .pkt_ready (pkt_ready),
    .pkt_valid (pkt_valid),
    .pkt_vec   (pkt_vec),
    .pend      (pend)
  );

  irq_remote_in #(.NVEC(NVEC), .AW(AW)) u_rin (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_vec  (rx_vec),
    .redirect(redirect),
    .ptr     (ptr),
    .to_stat (rx_set),
    .wr_valid(ptr_wr_valid),
    .wr_addr (ptr_wr_addr),
    .wr_data (ptr_wr_data)
  );

  irq_stat_reg #(.NVEC(NVEC)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(local_set | rx_set),
    .clr_vec(clr_vec),
    .stat   (stat)
  );

  assign host_irq = |stat;

  always_comb begin
    reg_rdata = '0;
    case (addr)
      RA_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
      RA_PEND: reg_rdata[NVEC-1:0]   = pend;
      RA_STAT: reg_rdata[NVEC-1:0]   = stat;
      RA_PTR:  reg_rdata[AW-1:0]     = ptr;
      default: reg_rdata = '0;
    endcase
  end

  // R9
  rx_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !redirect) |=> ((stat & $past(rx_vec)) == $past(rx_vec) && host_irq == ($past(rx_vec) != '0) || host_irq));

  // R2
  local_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (local_mode && !(pkt_valid && pkt_ready)) |=> $stable(pend));
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NVEC = 15;
  localparam logic [NVEC-1:0] VMASK = '1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            err_local = 1'b0;
  logic            err_remote = 1'b0;
  logic            pkt_valid;
  logic            pkt_ready = 1'b0;
  logic [NVEC-1:0] pkt_vec;
  logic            rx_valid = 1'b0;
  logic [NVEC-1:0] rx_vec = '0;
  logic            ptr_wr_valid;
  logic [31:0]     ptr_wr_addr;
  logic [NVEC-1:0] ptr_wr_data;
  logic            host_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  logic [1:0]      m_ctrl;
  logic [NVEC-1:0] m_pend, m_stat, m_pvec, m_wdata;
  logic [31:0]     m_ptr, m_waddr;
  logic            m_pv, m_wv;

  always #5 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_local(err_local),
    .err_remote(err_remote), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_vec(pkt_vec), .rx_valid(rx_valid), .rx_vec(rx_vec),
    .ptr_wr_valid(ptr_wr_valid), .ptr_wr_addr(ptr_wr_addr),
    .ptr_wr_data(ptr_wr_data), .host_irq(host_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: m_read = {30'd0, m_ctrl};
      2'd1: m_read = {17'd0, m_pend};
      2'd2: m_read = {17'd0, m_stat};
      default: m_read = m_ptr;
    endcase
  endfunction

  // model step on each edge, then compare once outputs settle
  always @(posedge clk) begin
    logic [NVEC-1:0] sets, clrs;
    logic ack;
    cycles++;
    if (!rst_n) begin
      m_ctrl = 0; m_pend = 0; m_stat = 0; m_pvec = 0; m_ptr = 0;
      m_pv = 0; m_wv = 0; m_wdata = 0; m_waddr = 0;
    end else begin
      sets = ((reg_we && reg_addr == 2'd1) ? reg_wdata[NVEC-1:0] : '0);
      sets[13] = sets[13] | err_local;
      sets[14] = sets[14] | err_remote;
      clrs = (reg_we && reg_addr == 2'd2) ? reg_wdata[NVEC-1:0] : '0;
      ack = m_pv && pkt_ready;
      m_wv = rx_valid && m_ctrl[1];
      if (m_wv) begin m_wdata = rx_vec; m_waddr = m_ptr; end
      m_stat = m_stat & ~clrs;
      if (m_ctrl[0]) m_stat = m_stat | sets;
      if (rx_valid && !m_ctrl[1]) m_stat = m_stat | rx_vec;
      if (ack) m_pv = 0;
      else if (!m_pv && !m_ctrl[0] && m_pend != 0) begin m_pv = 1; m_pvec = m_pend; end
      if (ack) m_pend = m_pend & ~m_pvec;
      if (!m_ctrl[0]) m_pend = m_pend | sets;
      if (reg_we && reg_addr == 2'd0) m_ctrl = reg_wdata[1:0];
      if (reg_we && reg_addr == 2'd3) m_ptr = reg_wdata;
    end
    #2;
    if (rst_n && !done) begin
      check("R5 host_irq", {31'd0, host_irq}, {31'd0, m_stat != 0});
      check("R6 pkt_valid", {31'd0, pkt_valid}, {31'd0, m_pv});
      if (m_pv) check("R7 pkt_vec", {17'd0, pkt_vec}, {17'd0, m_pvec});
      check("R10 ptr_wr_valid", {31'd0, ptr_wr_valid}, {31'd0, m_wv});
      if (m_wv) begin
        check("R10 ptr_wr_addr", ptr_wr_addr, m_waddr);
        check("R10 ptr_wr_data", {17'd0, ptr_wr_data}, {17'd0, m_wdata});
      end
      check("R11 reg_rdata", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic el, input logic er, input logic rdy,
                      input logic rv, input logic [NVEC-1:0] rvec);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; err_local = el; err_remote = er;
    pkt_ready = rdy; rx_valid = rv; rx_vec = rvec;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'(i), 0, 0, 0, 0, 0, 0);
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_we = 0; err_local = 0; err_remote = 0; rx_valid = 0; pkt_ready = 0;
    reg_addr = a; #1; v = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin peek(2'(a), v); check("R1 reg zero", v, 0); end
    check("R1 host_irq low", {31'd0, host_irq}, 0);
    check("R1 pkt_valid low", {31'd0, pkt_valid}, 0);

    // local routing: R2, R3
    step(1, 2'd0, 32'h1, 0, 0, 0, 0, 0);
    step(1, 2'd1, 32'h0005, 0, 0, 0, 0, 0);
    peek(2'd2, v); check("R2 status set", v, 32'h0005);
    peek(2'd1, v); check("R2 pend untouched", v, 0);
    step(0, 2'd0, 0, 1, 0, 0, 0, 0);
    peek(2'd2, v); check("R3 local err bit13", v, 32'h2005);
    step(0, 2'd0, 0, 0, 1, 0, 0, 0);
    peek(2'd2, v); check("R3 remote err bit14", v, 32'h6005);
    // R4 W1C
    step(1, 2'd2, 32'h0001, 0, 0, 0, 0, 0);
    peek(2'd2, v); check("R4 clear one", v, 32'h6004);
    step(1, 2'd2, 32'h0000, 0, 0, 0, 0, 0);
    peek(2'd2, v); check("R4 write zero no effect", v, 32'h6004);
    step(1, 2'd2, 32'h2000, 1, 0, 0, 0, 0);
    peek(2'd2, v); check("R4 set wins", v, 32'h6004);
    step(1, 2'd2, 32'h7FFF, 0, 0, 0, 0, 0);
    peek(2'd2, v); check("R4 all cleared", v, 0);
    check("R5 irq low when clear", {31'd0, host_irq}, 0);

    // remote routing: R6, R7, R8
    step(1, 2'd0, 32'h0, 0, 0, 0, 0, 0);
    step(1, 2'd1, 32'h0030, 0, 0, 0, 0, 0);
    idle(3);
    check("R6 pkt_valid", {31'd0, pkt_valid}, 1);
    check("R6 pkt_vec", {17'd0, pkt_vec}, 32'h30);
    step(1, 2'd1, 32'h0100, 0, 0, 0, 0, 0);
    idle(2);
    check("R7 pkt_vec held", {17'd0, pkt_vec}, 32'h30);
    step(0, 2'd0, 0, 0, 1, 1, 0, 0);
    step(0, 2'd1, 0, 0, 0, 0, 0, 0);
    check("R8 valid drops", {31'd0, pkt_valid}, 0);
    peek(2'd1, v); check("R8 pend keeps new", v, 32'h4100);
    idle(1);
    check("R6 relaunch vec", {17'd0, pkt_vec}, 32'h4100);
    step(0, 2'd0, 0, 0, 0, 1, 0, 0);
    idle(3);
    peek(2'd1, v); check("R8 pend empty", v, 0);

    // inbound: R9, R10
    step(0, 2'd0, 0, 0, 0, 0, 1, 15'h00A0);
    peek(2'd2, v); check("R9 status merge", v, 32'h00A0);
    step(1, 2'd2, 32'h7FFF, 0, 0, 0, 0, 0);
    step(1, 2'd3, 32'h1234_5678, 0, 0, 0, 0, 0);
    step(1, 2'd0, 32'h2, 0, 0, 0, 0, 0);
    step(0, 2'd2, 0, 0, 0, 0, 1, 15'h000F);
    @(negedge clk); rx_valid = 0;
    check("R10 wr_valid", {31'd0, ptr_wr_valid}, 1);
    check("R10 wr_addr", ptr_wr_addr, 32'h1234_5678);
    check("R10 wr_data", {17'd0, ptr_wr_data}, 32'h000F);
    peek(2'd2, v); check("R10 status unchanged", v, 0);

    // mixed traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[1], lfsr[3:2], {17'd0, lfsr[15:1]} & ((lfsr[3:2] == 0) ? 32'h3 : 32'hFFFF_FFFF),
           lfsr[4] & lfsr[5] & lfsr[6], lfsr[7] & lfsr[8] & lfsr[9], lfsr[10],
           lfsr[11] & lfsr[12], {lfsr[6:0], lfsr[15:8]});
    end
    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule